// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide flash device. It is fed one bus-write event per cycle (address and data, qualified by a strobe). It follows the multi-write unlock protocols that guard every command. When a protocol completes, it issues a single-cycle decoded command carrying the operands captured from the final write. It also holds the device's access mode: plain read, identifier read, or the fast-program mode that skips the unlock prefix. In identifier mode it supplies the bytes that a bus read must return.

Only address bits 10:0 take part in address matching. A write that does not fit the protocol in progress sends the decoder back to plain read. While the downstream program/erase engine reports busy, writes are not looked at. Program requests aimed at a write-protected block are dropped without any trace.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (plain read), `cmd_valid` is low, `cmd_kind` is 0 and `id_data` is 00h.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then data D at address P, give one `cmd_valid` pulse in the cycle after the last write. In that pulse `cmd_kind` is 4'b0010, `cmd_addr` is P and `cmd_data` is D. Address bits 16:11 of the unlock writes are ignored.
- R3: A single F0h write at any address gives a pulse with `cmd_kind` 4'b0001 and sets `mode` to 0. So does F0h at any address written after the AAh@555h, 55h@2AAh prefix.
- R4: The prefix followed by 90h@555h sets `mode` to 1 (identifier), and this lasts across any number of reads. In that mode `id_data` is chosen by `rd_addr[1:0]`: 00 gives 20h, 01 gives 23h, and 10 gives 01h if `prot_mask[rd_addr[16:14]]` is set and 00h if not. In any other mode `id_data` is 00h.
- R5: The prefix, 80h@555h, the prefix again and then 10h@555h give a pulse with `cmd_kind` 4'b0100.
- R6: The same five writes followed by 30h at block address B give a pulse with `cmd_kind` 4'b1000 and `cmd_addr` B.
- R7: The prefix followed by 20h@555h sets `mode` to 2 (bypass). In bypass, A0h at any address followed by D at P gives a program pulse (R2 encoding), and `mode` stays 2.
- R8: In bypass, 90h followed by 00h, both at any address, return `mode` to 0 without a pulse.
- R9: A write that breaks the sequence in progress sets `mode` to 0 and gives no pulse.
- R10: A program (standard or bypass) whose target block `prot_mask[P[16:14]]` is set gives no pulse.
- R11: A write with `busy` high has no effect: no pulse, and the sequence state and `mode` are unchanged.
- R12: Whenever `cmd_valid` is high, exactly one bit of `cmd_kind` is set. When it is low, `cmd_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Bus-write strobe, one cycle per write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Program/erase engine running; writes ignored |
| prot_mask | input | 8 | Per-block write-protect flags |
| rd_addr | input | 17 | Bus-read address for identifier data |
| cmd_valid | output | 1 | Decoded command pulse |
| cmd_kind | output | 4 | One-hot: bit0 reset, bit1 program, bit2 chip erase, bit3 block erase |
| cmd_addr | output | 17 | Address captured from the final write |
| cmd_data | output | 8 | Data captured from the final write |
| mode | output | 2 | 0 read, 1 identifier, 2 bypass |
| id_data | output | 8 | Identifier read byte |

## Verification
A corrupted sequence step is usually hidden until the write that ends a command. At that point the pulse is missing, of the wrong kind or extra, one cycle after the write. The bench therefore drives complete sequences, broken ones and ones that are paused by busy. A wrong mode is visible at once on `mode` and through `id_data` on the next read. So a reference model that compares every output on every clock exposes it within one cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_BYP  = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM,
    ST_ERS, ST_ERS_UNL1, ST_ERS_UNL2,
    ST_BYP_PGM, ST_BYP_EXIT
  } step_e;

  localparam int CMD_N    = 4;
  localparam int CMD_RST  = 0;
  localparam int CMD_PGM  = 1;
  localparam int CMD_CHIP = 2;
  localparam int CMD_BLK  = 3;

  localparam int CMP_W = 11;
  localparam logic [CMP_W-1:0] ADR_KEY1 = 11'h555;
  localparam logic [CMP_W-1:0] ADR_KEY2 = 11'h2AA;

  localparam logic [7:0] D_KEY1  = 8'hAA;
  localparam logic [7:0] D_KEY2  = 8'h55;
  localparam logic [7:0] D_ID    = 8'h90;
  localparam logic [7:0] D_PGM   = 8'hA0;
  localparam logic [7:0] D_BYP   = 8'h20;
  localparam logic [7:0] D_ERS   = 8'h80;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_BLK   = 8'h30;
  localparam logic [7:0] D_RST   = 8'hF0;
  localparam logic [7:0] D_BEXIT = 8'h00;

  localparam logic [7:0] ID_MFR = 8'h20;
  localparam logic [7:0] ID_DEV = 8'h23;
endpackage

// File: rtl/flash_cmd_blkprot.sv
module flash_cmd_blkprot #(
  parameter int ADDR_W = 17,
  parameter int NBLK   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBLK-1:0]   prot_mask,
  output logic              prot
);
  localparam int BLK_W = $clog2(NBLK);
  logic [BLK_W-1:0] blk;

  assign blk  = addr[ADDR_W-1 -: BLK_W];
  assign prot = prot_mask[blk];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              tgt_prot,
  output logic              cmd_valid,
  output logic [CMD_N-1:0]  cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output mode_e             mode
);
  step_e             step_q, step_n;
  mode_e             mode_q, mode_n;
  logic [CMD_N-1:0]  kind_n, kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, at_key1, at_key2;

  assign accept  = wr_valid & ~busy;
  assign at_key1 = (wr_addr[CMP_W-1:0] == ADR_KEY1);
  assign at_key2 = (wr_addr[CMP_W-1:0] == ADR_KEY2);

  always_comb begin
    step_n = step_q;
    mode_n = mode_q;
    kind_n = '0;
    if (accept) begin
      step_n = ST_IDLE;
      mode_n = MODE_READ;
      unique case (step_q)
        ST_IDLE: begin
          if (mode_q == MODE_BYP) begin
            if (wr_data == D_PGM) begin
              step_n = ST_BYP_PGM;
              mode_n = MODE_BYP;
            end else if (wr_data == D_ID) begin
              step_n = ST_BYP_EXIT;
              mode_n = MODE_BYP;
            end
          end else if (wr_data == D_RST) begin
            kind_n[CMD_RST] = 1'b1;
          end else if (wr_data == D_KEY1 && at_key1) begin
            step_n = ST_UNL1;
            mode_n = mode_q;
          end
        end
        ST_UNL1: if (wr_data == D_KEY2 && at_key2) begin
          step_n = ST_UNL2;
          mode_n = mode_q;
        end
        ST_UNL2: begin
          if (wr_data == D_RST) kind_n[CMD_RST] = 1'b1;
          else if (at_key1) begin
            if (wr_data == D_ID)       mode_n = MODE_ID;
            else if (wr_data == D_PGM) step_n = ST_PGM;
            else if (wr_data == D_BYP) mode_n = MODE_BYP;
            else if (wr_data == D_ERS) step_n = ST_ERS;
          end
        end
        ST_PGM: kind_n[CMD_PGM] = ~tgt_prot;
        ST_ERS: if (wr_data == D_KEY1 && at_key1) step_n = ST_ERS_UNL1;
        ST_ERS_UNL1: if (wr_data == D_KEY2 && at_key2) step_n = ST_ERS_UNL2;
        ST_ERS_UNL2: begin
          if (wr_data == D_CHIP && at_key1) kind_n[CMD_CHIP] = 1'b1;
          else if (wr_data == D_BLK)        kind_n[CMD_BLK]  = 1'b1;
        end
        ST_BYP_PGM: begin
          kind_n[CMD_PGM] = ~tgt_prot;
          mode_n          = MODE_BYP;
        end
        ST_BYP_EXIT: mode_n = MODE_READ;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      mode_q <= MODE_READ;
      kind_q <= '0;
    end else begin
      step_q <= step_n;
      mode_q <= mode_n;
      kind_q <= kind_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  assign cmd_valid = |kind_q;
  assign cmd_kind  = kind_q;
  assign cmd_addr  = addr_q;
  assign cmd_data  = data_q;
  assign mode      = mode_q;
endmodule

// File: rtl/flash_cmd_idread.sv
module flash_cmd_idread
  import flash_cmd_pkg::*;
(
  input  mode_e       mode,
  input  logic [1:0]  rd_sel,
  input  logic        rd_prot,
  output logic [7:0]  id_data
);
  always_comb begin
    id_data = 8'h00;
    if (mode == MODE_ID) begin
      unique case (rd_sel)
        2'b00:   id_data = ID_MFR;
        2'b01:   id_data = ID_DEV;
        2'b10:   id_data = {7'd0, rd_prot};
        default: id_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int NBLK   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [NBLK-1:0]   prot_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_valid,
  output logic [CMD_N-1:0]  cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [1:0]        mode,
  output logic [7:0]        id_data
);
  logic [1:0] rst_sync;
  logic       core_rst_n, wr_prot, rd_prot;
  mode_e      mode_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  flash_cmd_blkprot #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_wprot (
    .addr(wr_addr), .prot_mask(prot_mask), .prot(wr_prot));

  flash_cmd_blkprot #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_rprot (
    .addr(rd_addr), .prot_mask(prot_mask), .prot(rd_prot));

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(core_rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .tgt_prot(wr_prot),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .mode(mode_cur));

  flash_cmd_idread u_id (
    .mode(mode_cur), .rd_sel(rd_addr[1:0]), .rd_prot(rd_prot),
    .id_data(id_data));

  assign mode = mode_cur;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int NBLK   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic [NBLK-1:0]   prot_mask,
  input logic              cmd_valid,
  input logic [3:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic [1:0]        mode,
  input logic [7:0]        id_data
);
  localparam int BLK_W = $clog2(NBLK);
  logic [NBLK-1:0] pm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pm_prev <= '0;
    else        pm_prev <= prot_mask;
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(cmd_kind) == 1);                           // R12
  AST_KIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_kind == 4'd0);                                   // R12
  AST_NO_WRITE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !cmd_valid);                                          // R12
  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !cmd_valid);                                               // R11
  AST_BUSY_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));                                            // R11
  AST_CMD_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data))); // R2
  AST_PROT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind[1]) |-> !pm_prev[cmd_addr[ADDR_W-1 -: BLK_W]]); // R10
  AST_ID_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd1 |-> id_data == 8'h00);                                 // R4
  AST_BYP_ONLY_PGM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && cmd_valid) |-> cmd_kind == 4'b0010);        // R7
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBLK(NBLK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .prot_mask(prot_mask),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .mode(mode), .id_data(id_data));

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [7:0]  prot_mask = '0;
  logic [16:0] rd_addr = '0;
  logic        cmd_valid;
  logic [3:0]  cmd_kind;
  logic [16:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic [1:0]  mode;
  logic [7:0]  id_data;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model state
  int m_mode = 0, m_step = 0;
  bit e_valid = 0;
  int e_kind = 0, e_addr = 0, e_data = 0;
  // snapshot after each write
  bit s_valid; int s_kind, s_addr, s_data;

  always #5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .prot_mask(prot_mask), .rd_addr(rd_addr),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .mode(mode), .id_data(id_data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_id(int md, int ra, int pm);
    if (md != 1) return 0;
    case (ra % 4)
      0: return 'h20;
      1: return 'h23;
      2: return (pm >> (ra / 16384)) & 1;
      default: return 0;
    endcase
  endfunction

  // behavioural reference: decode by counting matched writes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_step = 0; e_valid = 0; e_kind = 0;
    end else begin
      e_valid = 0; e_kind = 0;
      if (wr_valid && !busy) begin
        int lo, d, nm, ns; bit pr;
        lo = wr_addr % 2048; d = wr_data; nm = 0; ns = 0;
        pr = ((prot_mask >> (wr_addr / 16384)) & 1) != 0;
        e_addr = wr_addr; e_data = wr_data;
        if (m_step == 0 && m_mode == 2) begin
          if (d == 'hA0) begin ns = 7; nm = 2; end
          else if (d == 'h90) begin ns = 8; nm = 2; end
        end else if (m_step == 0) begin
          if (d == 'hF0) e_kind = 1;
          else if (d == 'hAA && lo == 'h555) begin ns = 1; nm = m_mode; end
        end else if (m_step == 1) begin
          if (d == 'h55 && lo == 'h2AA) begin ns = 2; nm = m_mode; end
        end else if (m_step == 2) begin
          if (d == 'hF0) e_kind = 1;
          else if (lo == 'h555 && d == 'h90) nm = 1;
          else if (lo == 'h555 && d == 'hA0) ns = 3;
          else if (lo == 'h555 && d == 'h20) nm = 2;
          else if (lo == 'h555 && d == 'h80) ns = 4;
        end else if (m_step == 3) begin
          if (!pr) e_kind = 2;
        end else if (m_step == 4) begin
          if (d == 'hAA && lo == 'h555) ns = 5;
        end else if (m_step == 5) begin
          if (d == 'h55 && lo == 'h2AA) ns = 6;
        end else if (m_step == 6) begin
          if (d == 'h10 && lo == 'h555) e_kind = 4;
          else if (d == 'h30) e_kind = 8;
        end else if (m_step == 7) begin
          nm = 2; if (!pr) e_kind = 2;
        end
        m_mode = nm; m_step = ns; e_valid = (e_kind != 0);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cmd_valid == e_valid, "R12 cmd_valid", cmd_valid, e_valid);
      chk(cmd_kind == e_kind, "R12 cmd_kind", cmd_kind, e_kind);
      chk(mode == m_mode, "R9 mode", mode, m_mode);
      chk(id_data == exp_id(m_mode, rd_addr, prot_mask), "R4 id_data",
          id_data, exp_id(m_mode, rd_addr, prot_mask));
      if (e_valid) begin
        chk(cmd_addr == e_addr, "R2 cmd_addr", cmd_addr, e_addr);
        chk(cmd_data == e_data, "R2 cmd_data", cmd_data, e_data);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    wr_valid = 1; wr_addr = a[16:0]; wr_data = d[7:0];
    @(negedge clk);
    s_valid = cmd_valid; s_kind = cmd_kind; s_addr = cmd_addr; s_data = cmd_data;
    #1 wr_valid = 0;
  endtask

  task automatic unlock();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  task automatic rd(input int a);
    @(negedge clk); #1 rd_addr = a[16:0]; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mode == 0, "R1 mode", mode, 0);
    chk(cmd_valid == 0 && cmd_kind == 0, "R1 cmd", cmd_kind, 0);
    chk(id_data == 0, "R1 id_data", id_data, 0);

    // R2 program, upper bits of unlock addresses set
    wr('h1F555, 'hAA); wr('h0A2AA, 'h55); wr('h0D555, 'hA0);
    wr('h0C123, 'h5A);
    chk(s_valid && s_kind == 2, "R2 kind", s_kind, 2);
    chk(s_addr == 'h0C123 && s_data == 'h5A, "R2 operands", s_addr, 'h0C123);

    // R3 reset, short and long form
    wr('h12345, 'hF0);
    chk(s_valid && s_kind == 1, "R3 short", s_kind, 1);
    unlock(); wr('h00777, 'hF0);
    chk(s_valid && s_kind == 1 && mode == 0, "R3 long", s_kind, 1);

    // R4 identifier mode
    prot_mask = 8'b0010_0100;
    unlock(); wr('h555, 'h90);
    chk(mode == 1, "R4 enter", mode, 1);
    rd('h00000); chk(id_data == 'h20, "R4 mfr", id_data, 'h20);
    rd('h10001); chk(id_data == 'h23, "R4 dev", id_data, 'h23);
    rd('h08002); chk(id_data == 'h01, "R4 prot blk2", id_data, 1);
    rd('h0C002); chk(id_data == 'h00, "R4 unprot blk3", id_data, 0);
    rd('h14002); chk(id_data == 'h01, "R4 prot blk5", id_data, 1);
    chk(mode == 1, "R4 persists", mode, 1);
    wr('h0, 'hF0);
    rd('h00000); chk(mode == 0 && id_data == 0, "R4 leave", id_data, 0);

    // R9 broken sequences
    unlock(); wr('h555, 'h90);
    wr('h555, 'h12);
    chk(mode == 0 && !s_valid, "R9 from id", mode, 0);
    wr('h555, 'hAA); wr('h2AB, 'h55); wr('h555, 'hA0); wr('h4000, 'h11);
    chk(!s_valid && mode == 0, "R9 bad key", s_valid, 0);

    // R5 chip erase, R6 block erase
    unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10);
    chk(s_valid && s_kind == 4, "R5 chip", s_kind, 4);
    unlock(); wr('h555, 'h80); unlock(); wr('h14000, 'h30);
    chk(s_valid && s_kind == 8 && s_addr == 'h14000, "R6 block", s_kind, 8);

    // R10 protected program (block 2)
    unlock(); wr('h555, 'hA0); wr('h08010, 'h00);
    chk(!s_valid, "R10 std", s_valid, 0);

    // R7 bypass
    unlock(); wr('h555, 'h20);
    chk(mode == 2, "R7 enter", mode, 2);
    rd('h00000); chk(id_data == 0, "R7 reads plain", id_data, 0);
    wr('h1ABCD, 'hA0); wr('h04010, 'h3C);
    chk(s_valid && s_kind == 2 && s_addr == 'h04010 && s_data == 'h3C, "R7 pgm", s_kind, 2);
    wr('h0, 'hA0); wr('h1C001, 'h77);
    chk(s_valid && s_kind == 2 && mode == 2, "R7 again", mode, 2);
    wr('h0, 'hA0); wr('h14001, 'h77);
    chk(!s_valid && mode == 2, "R10 bypass", s_valid, 0);
    // R8 exit
    wr('h3, 'h90); wr('h7, 'h00);
    chk(mode == 0 && !s_valid, "R8 exit", mode, 0);

    // R11 busy
    busy = 1;
    unlock(); wr('h555, 'hA0); wr('h04000, 'h01);
    chk(!s_valid && mode == 0, "R11 whole seq", s_valid, 0);
    busy = 0;
    unlock();
    busy = 1; wr('h0, 'h99); busy = 0;
    wr('h555, 'hA0); wr('h04002, 'h02);
    chk(s_valid && s_kind == 2, "R11 paused seq", s_kind, 2);

    // R12 back-to-back resets
    wr('h0, 'hF0); wr('h0, 'hF0);
    chk(s_valid && $countones(s_kind) == 1, "R12 onehot", s_kind, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule